// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, cycle by cycle, which hardware thread of a single-issue, in-order, zero-overhead multithreaded pipeline gets the one issue slot. Every thread shows the block its next instruction: a valid flag, a load flag, two source register numbers and a destination register number. The block keeps one dependency scoreboard per thread. A load marks its destination register as busy for a fixed memory latency. Loads never block one another, so any number of them can be outstanding.

Two scheduling policies are available, chosen by a mode input. In rotate mode the selection steps to the next thread on every cycle. A slot that lands on a blocked thread is lost as a bubble. In sticky mode the current thread keeps the slot for as long as its next instruction can issue. Once that instruction is blocked, the slot passes with no penalty to the first ready thread found, searching onward from the current one. The outputs are the selected thread number, an issue strobe and an idle flag.

Top module: `mt_issue_sel`

## Requirements
- R1: In each cycle at most one thread issues. `issue_o` is high when the thread shown on `sel_thr_o` issues, and `idle_o` is high exactly in the cycles where nothing issues.
- R2: A thread can issue only if its valid flag is high and neither of its source registers is marked busy in that thread's own scoreboard.
- R3: A load with destination register d, issued in cycle t, blocks every reader of d in that thread during cycles t+1 to t+LOAD_LAT-1. A reader can issue again in cycle t+LOAD_LAT (LOAD_LAT = 100 by default).
- R4: A non-load instruction never marks a register busy, so a dependent instruction can issue in the very next cycle.
- R5: With `mode_i` = 0 (rotate), `sel_thr_o` advances by one every cycle, wrapping from NTHR-1 to 0, whether or not the selected thread is ready. A blocked or invalid thread's slot is a bubble.
- R6: With `mode_i` = 1 (sticky), a thread that issued in the previous cycle and is still ready stays selected.
- R7: In sticky mode, when the current thread is not ready, the block selects the first ready thread at current+1, current+2, … (wrapping modulo NTHR) and issues from it in the same cycle.
- R8: In sticky mode, when no thread is ready, `issue_o` is low and `idle_o` is high.
- R9: A load whose destination is register 0 marks nothing busy.
- R10: Loads are non-blocking and scoreboards are per thread. A second load issues in the cycle after a first load, and another thread reading the same register number is not blocked.
- R11: After reset, thread 0 is selected and no register of any thread is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = rotate every cycle, 1 = sticky until stall |
| thr_valid_i | input | NTHR | Per-thread next-instruction valid |
| thr_load_i | input | NTHR | Per-thread next instruction is a load |
| thr_rs1_i | input | NTHR x RW | Per-thread first source register |
| thr_rs2_i | input | NTHR x RW | Per-thread second source register |
| thr_rd_i | input | NTHR x RW | Per-thread destination register |
| sel_thr_o | output | TW | Selected thread |
| issue_o | output | 1 | Selected thread issues this cycle |
| idle_o | output | 1 | No thread issues this cycle |

## Verification
The assertions check four things on every cycle: rotation by one in rotate mode, staying on a still-ready thread in sticky mode, issuing only from a valid thread, and idling in sticky mode only when no thread is ready. The exact load window can only be shown by the bench's scenarios. Those scenarios count the cycle in which a blocked reader first issues, show the wrapped search order, confirm that a load to register zero is harmless, and check that one thread's scoreboard does not affect another thread.

// File: rtl/mt_issue_pkg.sv
package mt_issue_pkg;
    typedef enum logic {
        SEL_ROTATE = 1'b0,
        SEL_STICKY = 1'b1
    } sel_mode_e;
endpackage

// File: rtl/mt_thr_sb.sv
// Per-thread load scoreboard: one busy bit and one down-counter per register.
module mt_thr_sb #(
    parameter int NREG     = 32,
    parameter int LOAD_LAT = 100,
    parameter int RW       = $clog2(NREG),
    parameter int CW       = $clog2(LOAD_LAT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          load_i,
    input  logic [RW-1:0] rs1_i,
    input  logic [RW-1:0] rs2_i,
    input  logic [RW-1:0] rd_i,
    input  logic          issue_i,
    output logic          ready_o
);
    localparam logic [CW-1:0] ARM_VAL = CW'(LOAD_LAT - 1);

    typedef struct packed {
        logic [NREG-1:0]         busy;
        logic [NREG-1:0][CW-1:0] cnt;
    } sb_t;

    sb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int r = 0; r < NREG; r++) begin
            if (s_q.busy[r]) begin
                if (s_q.cnt[r] <= CW'(1)) begin
                    s_d.busy[r] = 1'b0;
                    s_d.cnt[r]  = '0;
                end else begin
                    s_d.cnt[r] = s_q.cnt[r] - CW'(1);
                end
            end
        end
        if (issue_i && load_i && (rd_i != '0)) begin
            s_d.busy[rd_i] = 1'b1;
            s_d.cnt[rd_i]  = ARM_VAL;
        end
        ready_o = valid_i && !s_q.busy[rs1_i] && !s_q.busy[rs2_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/mt_pick.sv
// Selection policy: rotate every cycle, or hold until stall and search onward.
module mt_pick
    import mt_issue_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int TW   = $clog2(NTHR)
) (
    input  sel_mode_e       mode_i,
    input  logic [TW-1:0]   ptr_i,
    input  logic [NTHR-1:0] rdy_i,
    output logic [TW-1:0]   pick_o,
    output logic            ok_o,
    output logic [TW-1:0]   ptr_nxt_o
);
    logic [TW-1:0] cand [NTHR];

    for (genvar g = 0; g < NTHR; g++) begin : g_cand
        always_comb begin
            if (int'(ptr_i) + g >= NTHR) begin
                cand[g] = TW'(int'(ptr_i) + g - NTHR);
            end else begin
                cand[g] = TW'(int'(ptr_i) + g);
            end
        end
    end

    always_comb begin
        pick_o    = ptr_i;
        ok_o      = 1'b0;
        ptr_nxt_o = ptr_i;
        if (mode_i == SEL_ROTATE) begin
            ok_o      = rdy_i[ptr_i];
            ptr_nxt_o = cand[(NTHR > 1) ? 1 : 0];
        end else begin
            for (int k = 0; k < NTHR; k++) begin
                if (!ok_o && rdy_i[cand[k]]) begin
                    ok_o   = 1'b1;
                    pick_o = cand[k];
                end
            end
            ptr_nxt_o = pick_o;
        end
    end
endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel
    import mt_issue_pkg::*;
#(
    parameter int NTHR     = 4,
    parameter int NREG     = 32,
    parameter int LOAD_LAT = 100,
    localparam int RW      = $clog2(NREG),
    localparam int TW      = $clog2(NTHR)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_i,
    input  logic [NTHR-1:0]         thr_valid_i,
    input  logic [NTHR-1:0]         thr_load_i,
    input  logic [NTHR-1:0][RW-1:0] thr_rs1_i,
    input  logic [NTHR-1:0][RW-1:0] thr_rs2_i,
    input  logic [NTHR-1:0][RW-1:0] thr_rd_i,
    output logic [TW-1:0]           sel_thr_o,
    output logic                    issue_o,
    output logic                    idle_o
);
    localparam int CW = $clog2(LOAD_LAT);

    typedef struct packed {
        logic [TW-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    logic [NTHR-1:0] rdy_w;
    logic [NTHR-1:0] iss_w;
    logic [TW-1:0]   pick_w;
    logic            ok_w;
    logic [TW-1:0]   ptr_nxt_w;
    sel_mode_e       mode_w;

    assign mode_w = sel_mode_e'(mode_i);

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        mt_thr_sb #(
            .NREG(NREG), .LOAD_LAT(LOAD_LAT), .RW(RW), .CW(CW)
        ) u_sb (
            .clk    (clk),
            .rst_n  (rst_n),
            .valid_i(thr_valid_i[t]),
            .load_i (thr_load_i[t]),
            .rs1_i  (thr_rs1_i[t]),
            .rs2_i  (thr_rs2_i[t]),
            .rd_i   (thr_rd_i[t]),
            .issue_i(iss_w[t]),
            .ready_o(rdy_w[t])
        );
        assign iss_w[t] = ok_w && (pick_w == TW'(t));
    end

    mt_pick #(.NTHR(NTHR), .TW(TW)) u_pick (
        .mode_i   (mode_w),
        .ptr_i    (st_q.ptr),
        .rdy_i    (rdy_w),
        .pick_o   (pick_w),
        .ok_o     (ok_w),
        .ptr_nxt_o(ptr_nxt_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ptr  = ptr_nxt_w;
        sel_thr_o = pick_w;
        issue_o   = ok_w;
        idle_o    = !ok_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mt_issue_chk.sv
module mt_issue_chk #(
    parameter int NTHR = 4,
    parameter int TW   = $clog2(NTHR)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode_i,
    input logic [NTHR-1:0] thr_valid_i,
    input logic [NTHR-1:0] rdy_w,
    input logic [TW-1:0]   sel_thr_o,
    input logic            issue_o,
    input logic            idle_o
);
    function automatic logic [TW-1:0] step(input logic [TW-1:0] p);
        return (int'(p) == NTHR - 1) ? '0 : TW'(int'(p) + 1);
    endfunction

    AST_RR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !mode_i && !$past(mode_i)) |-> (sel_thr_o == step($past(sel_thr_o)))); // R5

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_i && $past(mode_i) && $past(issue_o) && rdy_w[$past(sel_thr_o)])
        |-> (sel_thr_o == $past(sel_thr_o))); // R6

    AST_ISSUE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> thr_valid_i[sel_thr_o]); // R2

    AST_STICKY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && idle_o) |-> (rdy_w == '0)); // R8
endmodule

bind mt_issue_sel mt_issue_chk #(.NTHR(NTHR), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .thr_valid_i(thr_valid_i),
    .rdy_w      (rdy_w),
    .sel_thr_o  (sel_thr_o),
    .issue_o    (issue_o),
    .idle_o     (idle_o)
);

// File: tb/sim_mt_issue_sel.sv
module sim_mt_issue_sel;
    localparam int NT = 4;
    localparam int LAT = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode;
    logic [NT-1:0] vld, ld;
    logic [NT-1:0][4:0] rs1, rs2, rd;
    logic [1:0] sel;
    logic issue, idle;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mt_issue_sel u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .thr_valid_i(vld), .thr_load_i(ld),
        .thr_rs1_i(rs1), .thr_rs2_i(rs2), .thr_rd_i(rd),
        .sel_thr_o(sel), .issue_o(issue), .idle_o(idle)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic setthr(input int t, input logic v, input logic l,
                          input int a, input int b, input int d);
        vld[t] = v; ld[t] = l;
        rs1[t] = 5'(a); rs2[t] = 5'(b); rd[t] = 5'(d);
    endtask

    task automatic adv();
        @(posedge clk); #1;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic until_issue(inout int c);
        smp();
        while (!issue && c < 1000) begin
            adv(); c++; smp();
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int c;
        mode = 1'b0;
        for (int t = 0; t < NT; t++) setthr(t, 0, 0, 0, 0, 0);

        // R11 reset state
        do_reset(); smp();
        chk("R11 sel", sel, 0);
        chk("R11 issue", issue, 0);
        chk("R1 idle", idle, 1);

        // R5 rotation, all threads ready
        for (int t = 0; t < NT; t++) setthr(t, 1, 0, 1, 2, 3);
        do_reset();
        for (int k = 0; k < 8; k++) begin
            smp();
            chk("R5 sel", sel, k % NT);
            chk("R1 issue", issue, 1);
            adv();
        end
        // R5 bubble on an invalid thread
        setthr(2, 0, 0, 1, 2, 3);
        for (int k = 8; k < 16; k++) begin
            smp();
            chk("R5 sel", sel, k % NT);
            chk("R5 bubble issue", issue, (k % NT) != 2);
            chk("R1 idle", idle, (k % NT) == 2);
            adv();
        end

        // R4, R9, R3 single thread, sticky
        mode = 1'b1;
        for (int t = 0; t < NT; t++) setthr(t, 0, 0, 0, 0, 0);
        setthr(0, 1, 0, 1, 2, 6);
        do_reset(); smp();
        chk("R4 c0", issue, 1);
        adv(); setthr(0, 1, 0, 6, 0, 7); smp();
        chk("R4 dependent next cycle", issue, 1);
        adv(); setthr(0, 1, 1, 0, 0, 0); smp();
        chk("R9 load rd0 issue", issue, 1);
        adv(); setthr(0, 1, 1, 0, 0, 8); smp();
        chk("R9 reader of r0 after rd0 load", issue, 1);
        adv(); setthr(0, 1, 0, 0, 8, 9); smp();
        chk("R3 reader blocked", issue, 0);
        chk("R8 idle", idle, 1);
        c = 4;
        adv(); c++;
        until_issue(c);
        chk("R3 first issue cycle", c, 3 + LAT);

        // R6, R7, R8, R3 with four threads
        for (int t = 1; t < NT; t++) setthr(t, 1, 0, 1, 2, 3);
        setthr(0, 1, 1, 0, 0, 7);
        do_reset(); smp();
        chk("R1 c0 sel", sel, 0);
        chk("R1 c0 issue", issue, 1);
        adv(); setthr(0, 1, 0, 7, 0, 4); smp();
        chk("R7 switch to next", sel, 1);
        chk("R7 no penalty", issue, 1);
        for (int k = 2; k < 5; k++) begin
            adv(); smp();
            chk("R6 stay", sel, 1);
        end
        adv(); setthr(1, 0, 0, 1, 2, 3); smp();
        chk("R7 onward search", sel, 2);
        chk("R7 issue", issue, 1);
        adv(); setthr(2, 0, 0, 1, 2, 3); setthr(3, 0, 0, 1, 2, 3); smp();
        chk("R8 all blocked issue", issue, 0);
        chk("R8 all blocked idle", idle, 1);
        c = 6;
        adv(); c++;
        until_issue(c);
        chk("R3 wake cycle", c, LAT);
        chk("R3 wake sel", sel, 0);
        adv(); setthr(0, 0, 0, 0, 0, 0); setthr(3, 1, 0, 1, 2, 3); smp();
        chk("R7 to thread 3", sel, 3);
        adv(); setthr(3, 0, 0, 1, 2, 3); setthr(0, 1, 0, 0, 0, 5);
        setthr(2, 1, 0, 1, 2, 3); smp();
        chk("R7 wrap order", sel, 0);

        // R10 non-blocking loads and per-thread scoreboards
        for (int t = 0; t < NT; t++) setthr(t, 0, 0, 0, 0, 0);
        setthr(0, 1, 1, 0, 0, 9);
        do_reset(); smp();
        chk("R10 first load", issue, 1);
        adv(); setthr(0, 1, 1, 1, 0, 10); smp();
        chk("R10 back-to-back load sel", sel, 0);
        chk("R10 back-to-back load issue", issue, 1);
        adv(); setthr(0, 1, 0, 10, 9, 4); setthr(1, 1, 0, 0, 9, 4); smp();
        chk("R10 other thread unaffected sel", sel, 1);
        chk("R10 other thread unaffected issue", issue, 1);
        adv(); setthr(1, 0, 0, 0, 0, 0); smp();
        chk("R2 blocked on two loads", issue, 0);
        c = 3;
        adv(); c++;
        until_issue(c);
        chk("R3 second load window", c, 1 + LAT);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule